// File: doc/BRIEF.md
# ECC Syndrome Checker and Corrector

This block compares a 22-bit error-correcting code recomputed from a 256-byte data chunk with the 22-bit code that was kept alongside that chunk in flash spare bytes. From the XOR of the two codes, the syndrome, it decides which of four outcomes applies:

- the chunk is clean;
- only the stored code was damaged;
- one data bit flipped and can be repaired;
- the damage is beyond repair.

For a repairable chunk it reports the byte to patch and an 8-bit mask to XOR into that byte.

A wide-page input selects whether one chunk or all chunks are judged. With two chunks this covers a 512-byte page. Each chunk has its own code pair and its own correction lane. The lane of the second chunk reports byte addresses offset by 256. The per-chunk verdicts merge into one status code, which is the most severe verdict. A one-cycle start strobe latches the inputs. The registered result appears with a valid pulse on the following cycle and then holds until the next strobe.

Top module: `ecc_syndrome_fix`

## Requirements
- R1: When the calculated and stored codes of every judged chunk are equal, status is 0 (clean) and all flip masks are zero.
- R2: A chunk whose calculated code or stored code is entirely zero is judged clean, whatever the other code holds.
- R3: A syndrome with exactly one bit set gives status 1 (stored-code damage), with all flip masks zero.
- R4: A syndrome with exactly 11 ones, whose bits [10:0] XOR bits [21:11] equal all ones, gives status 2 (corrected). That lane's mask is 1 shifted left by syndrome[2:0], and its address is syndrome[10:3] plus 256 times the chunk index.
- R5: Any other nonzero syndrome, with both codes nonzero, gives status 3 (uncorrectable). Examples are two bits set, 11 ones without complementary halves, and all 22 bits set.
- R6: With wide_mode high, chunk 1 is judged from bits [43:22] of the code inputs. The merged status is the numerically largest chunk status. Flip masks and addresses are nonzero only when the merged status is 2, and then only for lanes whose own status is 2.
- R7: With wide_mode low, chunk 1 inputs are ignored. Status comes from chunk 0 alone, and lane 1 address and mask are zero.
- R8: out_valid pulses exactly one cycle after each start cycle. Outputs change only on the cycle after start, so code inputs changed without start leave them untouched.
- R9: After reset, out_valid, status, addresses and masks are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch and judge the current inputs |
| wide_mode | input | 1 | 1: judge all chunks (512-byte page); 0: chunk 0 only |
| calc_codes | input | 44 | Recomputed codes, chunk k in bits [22k+21:22k] |
| stored_codes | input | 44 | Codes read from spare bytes, same packing |
| out_valid | output | 1 | Result registered this cycle |
| status | output | 2 | 0 clean, 1 stored-code damage, 2 corrected, 3 uncorrectable |
| fix_addrs | output | 18 | Byte address per lane, lane k in bits [9k+8:9k] |
| fix_masks | output | 16 | Flip mask per lane, lane k in bits [8k+7:8k] |

## Verification
The hardest case to reach from the ports is a correctable verdict, because a random syndrome almost never has exactly 11 ones split into complementary halves. The bench builds such syndromes directly: the low half is set to the byte and bit index, and the high half to its inverse. The result is XORed onto a nonzero calculated code. Mixed wide-mode cases then combine a corrected chunk with a damaged-spare, clean or uncorrectable partner. These cases exercise severity merging and mask suppression.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    localparam int CODE_W      = 22;
    localparam int HALF_W      = CODE_W / 2;
    localparam int BIT_W       = 3;
    localparam int BYTE_W      = HALF_W - BIT_W;
    localparam int MASK_W      = 1 << BIT_W;
    localparam int CHUNK_BYTES = 1 << BYTE_W;

    typedef enum logic [1:0] {
        ECC_CLEAN     = 2'd0,
        ECC_SPARE_BAD = 2'd1,
        ECC_FIXED     = 2'd2,
        ECC_FATAL     = 2'd3
    } ecc_status_e;

    typedef struct packed {
        ecc_status_e          status;
        logic [BYTE_W-1:0]    byte_idx;
        logic [BIT_W-1:0]     bit_idx;
    } chunk_verdict_t;

    function automatic int unsigned ones_count(input logic [CODE_W-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < CODE_W; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

    function automatic ecc_status_e worse_of(input ecc_status_e a, input ecc_status_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ecc_chunk_judge.sv
module ecc_chunk_judge
    import ecc_fix_pkg::*;
(
    input  logic [CODE_W-1:0] calc_code,
    input  logic [CODE_W-1:0] stored_code,
    output chunk_verdict_t    verdict
);

    logic [CODE_W-1:0] syn;
    logic [HALF_W-1:0] pair_xor;
    int unsigned       weight;

    always_comb begin
        syn      = calc_code ^ stored_code;
        pair_xor = syn[HALF_W-1:0] ^ syn[CODE_W-1:HALF_W];
        weight   = ones_count(syn);

        verdict.byte_idx = '0;
        verdict.bit_idx  = '0;
        if (syn == '0 || calc_code == '0 || stored_code == '0) begin
            verdict.status = ECC_CLEAN;
        end else if (weight == 1) begin
            verdict.status = ECC_SPARE_BAD;
        end else if (weight == HALF_W && pair_xor == '1) begin
            verdict.status   = ECC_FIXED;
            verdict.bit_idx  = syn[BIT_W-1:0];
            verdict.byte_idx = syn[HALF_W-1:BIT_W];
        end else begin
            verdict.status = ECC_FATAL;
        end
    end

endmodule

// File: rtl/ecc_lane_merge.sv
module ecc_lane_merge
    import ecc_fix_pkg::*;
#(
    parameter int NUM_CHUNKS = 2,
    parameter int ADDR_W     = 9
) (
    input  chunk_verdict_t [NUM_CHUNKS-1:0] verdicts,
    input  logic                            wide_mode,
    output ecc_status_e                     merged,
    output logic [NUM_CHUNKS*ADDR_W-1:0]    addrs,
    output logic [NUM_CHUNKS*MASK_W-1:0]    masks
);

    logic [NUM_CHUNKS-1:0] lane_on;

    always_comb begin
        merged = ECC_CLEAN;
        for (int k = 0; k < NUM_CHUNKS; k++) begin
            lane_on[k] = (k == 0) || wide_mode;
            if (lane_on[k]) begin
                merged = worse_of(merged, verdicts[k].status);
            end
        end
    end

    generate
        for (genvar k = 0; k < NUM_CHUNKS; k++) begin : g_lane
            logic patch;
            assign patch = lane_on[k] && merged == ECC_FIXED && verdicts[k].status == ECC_FIXED;
            assign addrs[k*ADDR_W +: ADDR_W] = patch ?
                (ADDR_W'(k * CHUNK_BYTES) + ADDR_W'(verdicts[k].byte_idx)) : '0;
            assign masks[k*MASK_W +: MASK_W] = patch ?
                (MASK_W'(1) << verdicts[k].bit_idx) : '0;
        end
    endgenerate

endmodule

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix
    import ecc_fix_pkg::*;
#(
    parameter int NUM_CHUNKS = 2,
    localparam int ADDR_W    = $clog2(NUM_CHUNKS * CHUNK_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         wide_mode,
    input  logic [NUM_CHUNKS*CODE_W-1:0] calc_codes,
    input  logic [NUM_CHUNKS*CODE_W-1:0] stored_codes,
    output logic                         out_valid,
    output logic [1:0]                   status,
    output logic [NUM_CHUNKS*ADDR_W-1:0] fix_addrs,
    output logic [NUM_CHUNKS*MASK_W-1:0] fix_masks
);

    chunk_verdict_t [NUM_CHUNKS-1:0] verdicts;
    ecc_status_e                     merged;
    logic [NUM_CHUNKS*ADDR_W-1:0]    addrs_c;
    logic [NUM_CHUNKS*MASK_W-1:0]    masks_c;

    generate
        for (genvar k = 0; k < NUM_CHUNKS; k++) begin : g_chunk
            ecc_chunk_judge u_judge (
                .calc_code   (calc_codes[k*CODE_W +: CODE_W]),
                .stored_code (stored_codes[k*CODE_W +: CODE_W]),
                .verdict     (verdicts[k])
            );
        end
    endgenerate

    ecc_lane_merge #(
        .NUM_CHUNKS (NUM_CHUNKS),
        .ADDR_W     (ADDR_W)
    ) u_merge (
        .verdicts  (verdicts),
        .wide_mode (wide_mode),
        .merged    (merged),
        .addrs     (addrs_c),
        .masks     (masks_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            status    <= '0;
            fix_addrs <= '0;
            fix_masks <= '0;
        end else begin
            out_valid <= start;
            if (start) begin
                status    <= merged;
                fix_addrs <= addrs_c;
                fix_masks <= masks_c;
            end
        end
    end

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> out_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !start |=> !out_valid); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(status) && $stable(fix_masks) && $stable(fix_addrs))); // R8
    AST_MASK_ONLY_FIXED: assert property (@(posedge clk) disable iff (rst)
        (status != 2'(ECC_FIXED)) |-> (fix_masks == '0)); // R6

    generate
        for (genvar k = 0; k < NUM_CHUNKS; k++) begin : g_chk
            AST_MASK_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
                $onehot0(fix_masks[k*MASK_W +: MASK_W])); // R4
        end
        if (NUM_CHUNKS > 1) begin : g_narrow_chk
            AST_NARROW_UPPER_IDLE: assert property (@(posedge clk) disable iff (rst)
                (out_valid && !$past(wide_mode)) |->
                (fix_masks[NUM_CHUNKS*MASK_W-1:MASK_W] == '0)); // R7
        end
    endgenerate

endmodule

// File: tb/ecc_syndrome_fix_tb.sv
module ecc_syndrome_fix_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        wide_mode;
    logic [43:0] calc_codes;
    logic [43:0] stored_codes;
    logic        out_valid;
    logic [1:0]  status;
    logic [17:0] fix_addrs;
    logic [15:0] fix_masks;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [1:0]  st;
        logic [17:0] addr;
        logic [15:0] mask;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    ecc_syndrome_fix u_dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .wide_mode    (wide_mode),
        .calc_codes   (calc_codes),
        .stored_codes (stored_codes),
        .out_valid    (out_valid),
        .status       (status),
        .fix_addrs    (fix_addrs),
        .fix_masks    (fix_masks)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] judge(input logic [21:0] c, input logic [21:0] s,
                                         output logic [7:0] byt, output logic [2:0] bt);
        logic [21:0] y;
        y   = c ^ s;
        byt = y[10:3];
        bt  = y[2:0];
        if (y == 0 || c == 0 || s == 0) return 2'd0;
        if ($countones(y) == 1) return 2'd1;
        if ($countones(y) == 11 && (y[10:0] ^ y[21:11]) == 11'h7FF) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [21:0] fix_syn(input logic [7:0] byt, input logic [2:0] bt);
        return {~{byt, bt}, {byt, bt}};
    endfunction

    task automatic send(input string tag, input logic wide,
                        input logic [21:0] c0, input logic [21:0] s0,
                        input logic [21:0] c1, input logic [21:0] s1);
        exp_t e;
        logic [1:0] st0, st1, m;
        logic [7:0] b0, b1;
        logic [2:0] t0, t1;
        st0 = judge(c0, s0, b0, t0);
        st1 = wide ? judge(c1, s1, b1, t1) : 2'd0;
        if (!wide) begin b1 = 0; t1 = 0; end
        m = (st0 > st1) ? st0 : st1;
        e.st = m; e.addr = '0; e.mask = '0; e.tag = tag;
        if (m == 2'd2 && st0 == 2'd2) begin
            e.addr[8:0] = {1'b0, b0};
            e.mask[7:0] = 8'd1 << t0;
        end
        if (m == 2'd2 && st1 == 2'd2) begin
            e.addr[17:9] = 9'd256 + 9'(b1);
            e.mask[15:8] = 8'd1 << t1;
        end
        sb.push_back(e);
        @(negedge clk);
        wide_mode    = wide;
        calc_codes   = {c1, c0};
        stored_codes = {s1, s0};
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                chk("R8", "unexpected valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "status", 32'(status), 32'(e.st));
                chk(e.tag, "addrs", 32'(fix_addrs), 32'(e.addr));
                chk(e.tag, "masks", 32'(fix_masks), 32'(e.mask));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0]  h_st;
        logic [17:0] h_ad;
        logic [15:0] h_mk;
        logic [21:0] c;
        rst = 1'b1; start = 1'b0; wide_mode = 1'b0;
        calc_codes = '0; stored_codes = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "valid", 32'(out_valid), 32'd0);
        chk("R9", "status", 32'(status), 32'd0);
        chk("R9", "addrs", 32'(fix_addrs), 32'd0);
        chk("R9", "masks", 32'(fix_masks), 32'd0);

        c = 22'h12345;
        send("R1", 1'b0, c, c, 22'h0, 22'h0);
        send("R1", 1'b1, 22'h3ABCD, 22'h3ABCD, 22'h00F0F, 22'h00F0F);
        send("R2", 1'b0, 22'h0, 22'h2A5A5, 22'h0, 22'h0);
        send("R2", 1'b0, 22'h1F00F, 22'h0, 22'h0, 22'h0);
        send("R3", 1'b0, c, c ^ 22'h000001, 22'h0, 22'h0);
        send("R3", 1'b0, c, c ^ 22'h200000, 22'h0, 22'h0);
        send("R4", 1'b0, c, c ^ fix_syn(8'h00, 3'd0), 22'h0, 22'h0);
        send("R4", 1'b0, c, c ^ fix_syn(8'hFF, 3'd7), 22'h0, 22'h0);
        send("R4", 1'b0, c, c ^ fix_syn(8'h5A, 3'd3), 22'h0, 22'h0);
        send("R5", 1'b0, c, c ^ 22'h000003, 22'h0, 22'h0);
        send("R5", 1'b0, c, c ^ {11'h001, 11'h3FF}, 22'h0, 22'h0);
        send("R5", 1'b0, c, ~c, 22'h0, 22'h0);
        send("R6", 1'b1, c, c, c, c ^ fix_syn(8'h10, 3'd2));
        send("R6", 1'b1, c, c ^ fix_syn(8'h21, 3'd6), c, c ^ 22'h000400);
        send("R6", 1'b1, c, c ^ fix_syn(8'h21, 3'd6), c, c ^ 22'h000003);
        send("R6", 1'b1, c, c ^ fix_syn(8'h01, 3'd1), c, c ^ fix_syn(8'hFE, 3'd5));
        send("R6", 1'b1, c, c ^ 22'h000800, 22'h0, 22'h15555);
        send("R7", 1'b0, c, c, c, c ^ 22'h000003);
        send("R7", 1'b0, c, c ^ fix_syn(8'h33, 3'd4), c, c ^ fix_syn(8'h44, 3'd1));

        while (sb.size() != 0) @(negedge clk);
        h_st = status; h_ad = fix_addrs; h_mk = fix_masks;
        wide_mode = 1'b1;
        calc_codes = {c, c};
        stored_codes = {~c, ~c};
        repeat (3) @(negedge clk);
        chk("R8", "valid idle", 32'(out_valid), 32'd0);
        chk("R8", "status held", 32'(status), 32'(h_st));
        chk("R8", "addrs held", 32'(fix_addrs), 32'(h_ad));
        chk("R8", "masks held", 32'(fix_masks), 32'(h_mk));
        repeat (2) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule